// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a software watchdog. It holds a down-counter that decrements once per system clock while the timer is enabled. Software programs a start value, picks what happens on expiry, enables the timer, and must then keep writing a kick register before the count runs out. A kick restarts the countdown from the programmed value. If the count reaches zero, the block raises the selected action. The action is one of: a fixed-length reset request pulse, a non-maskable interrupt line, an ordinary interrupt line, or nothing beyond a flag.

The block has two reset inputs. `por_i` is power-on reset and clears everything. `rst_i` is the system reset, which the reset generator drives in answer to `rst_req_o`. `rst_i` clears the timer's control state but leaves two things alone: a sticky reset-source flag and the reset-request pulse generator. After a watchdog-caused reset, software can therefore read the flag and learn why the system restarted.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Read data appears on the cycle after the read strobe.

Register map (word offsets on `bus_addr_i`):
- 0 is control.
- 1 is the start value.
- 2 is the kick register.
- 3 is the live count.
- Any other offset reads as zero.

Top module: `wdog_top`

## Requirements
- R1: While control bit 0 (enable) is 1, the count read at offset 3 falls by exactly one per clock cycle.
- R2: When the count steps from 1 to 0, control bit 8 (expired flag) becomes 1 on that edge. The count then stays at 0 while enabled. A start value of 0 never expires.
- R3: Control bits [2:1] select the action: 0 none, 1 reset, 2 NMI, 3 interrupt. `nmi_o` (code 2) or `irq_o` (code 3) goes high one cycle after the expiry edge. It stays high until software writes 1 to control bit 8. At most one of the two lines is high at any time.
- R4: Any write to offset 2 reloads the count from the start value and takes priority over the decrement. A write to offset 1 stores the start value and also loads it into the count.
- R5: Clearing control bit 0 freezes the count. Setting it again resumes from the frozen value without a reload.
- R6: Expiry with action code 1 drives `rst_req_o` high for exactly RST_PULSE consecutive cycles, starting at the expiry edge. The pulse is unaffected by `rst_i`.
- R7: Control bit 9 (watchdog reset source) is set only by an expiry with action code 1. It survives `rst_i` and is cleared only by `por_i` or by writing 1 to bit 9.
- R8: `rst_i` or `por_i` clears the enable bit, action code, start value, count, expired flag and both interrupt lines.
- R9: `bus_rdata_o` returns the addressed register one cycle after `bus_rd_i`, returns zero for unmapped offsets, and holds its value when no read is strobed.
- R10: With action code 0, expiry sets the expired flag but raises none of `rst_req_o`, `nmi_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_i | input | 1 | System reset, synchronous, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the strobe |
| rst_req_o | output | 1 | Reset request pulse to the reset generator |
| nmi_o | output | 1 | Non-maskable interrupt line |
| irq_o | output | 1 | General-purpose interrupt line |

## Verification
Some behaviours are checked on every cycle by the assertions:
- the one-per-cycle decrement, the frozen count while disabled, and the reload on a kick;
- the count holding at zero;
- the two interrupt lines never being high together;
- the reset pulse never exceeding its length;
- the sticky flag rising only together with a reset pulse.

Other behaviours only the directed scenarios can show:
- the exact latency from enable to each output;
- that regular kicks keep the interrupt away;
- resumption after a freeze without a reload;
- that the source flag outlives a system reset raised during the pulse, yet falls to power-on reset;
- that a zero start value never fires.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_IRQ   = 2'd3
  } wdog_act_e;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_LOAD  = 1;
  localparam int OFS_KICK  = 2;
  localparam int OFS_COUNT = 3;

  localparam int BIT_EN     = 0;
  localparam int BIT_ACT_LO = 1;
  localparam int BIT_EXP    = 8;
  localparam int BIT_SRC    = 9;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              exp_flag,
  input  logic              src_flag,
  output logic              en,
  output wdog_act_e         act,
  output logic [CNT_W-1:0]  load_val,
  output logic              load_wr,
  output logic              kick,
  output logic              exp_clr,
  output logic              src_clr,
  output logic [DATA_W-1:0] rdata
);
  logic sel_ctrl, sel_load, sel_kick, sel_cnt;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] rd_mux;

  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_load = (addr == ADDR_W'(OFS_LOAD));
  assign sel_kick = (addr == ADDR_W'(OFS_KICK));
  assign sel_cnt  = (addr == ADDR_W'(OFS_COUNT));

  assign load_wr = wr_en && sel_load && !rst;
  assign kick    = wr_en && sel_kick && !rst;
  assign exp_clr = wr_en && sel_ctrl && wdata[BIT_EXP];
  assign src_clr = wr_en && sel_ctrl && wdata[BIT_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      act      <= ACT_NONE;
      load_val <= '0;
    end else if (wr_en) begin
      if (sel_ctrl) begin
        en  <= wdata[BIT_EN];
        act <= wdog_act_e'(wdata[BIT_ACT_LO +: 2]);
      end
      if (sel_load) load_val <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[BIT_EN]          = en;
    ctrl_view[BIT_ACT_LO +: 2] = act;
    ctrl_view[BIT_EXP]         = exp_flag;
    ctrl_view[BIT_SRC]         = src_flag;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)     rd_mux = ctrl_view;
    else if (sel_cnt) rd_mux = DATA_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             kick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic busy;
  assign busy   = load_wr || kick;
  assign expire = !rst && en && !busy && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load_wr)            cnt <= load_data;
    else if (kick)               cnt <= load_val;
    else if (en && cnt != '0)    cnt <= cnt - ONE;
  end

  p_dec_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !busy && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnt == '0) |=> (cnt == '0));
  p_kick_reload_r4: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == $past(load_val)));
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> $stable(cnt));
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      por,
  input  logic      expire,
  input  wdog_act_e act,
  input  logic      exp_clr,
  input  logic      src_clr,
  output logic      exp_flag,
  output logic      src_flag,
  output logic      rst_req,
  output logic      nmi,
  output logic      irq
);
  localparam int PULSE_W = $clog2(RST_PULSE + 1);

  wdog_act_e          exp_act;
  logic               fire_rst;
  logic [PULSE_W-1:0] pcnt;
  logic [PULSE_W:0]   hi_len;

  assign fire_rst = expire && (act == ACT_RESET);

  // System-reset domain: expired flag and interrupt lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_flag <= 1'b0;
      exp_act  <= ACT_NONE;
      nmi      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (expire) begin
        exp_flag <= 1'b1;
        exp_act  <= act;
      end else if (exp_clr) begin
        exp_flag <= 1'b0;
      end
      nmi <= exp_flag && (exp_act == ACT_NMI);
      irq <= exp_flag && (exp_act == ACT_IRQ);
    end
  end

  // Power-on domain: the reset pulse and the source flag outlive rst.
  always_ff @(posedge clk) begin
    if (por) begin
      src_flag <= 1'b0;
      rst_req  <= 1'b0;
      pcnt     <= '0;
    end else begin
      if (fire_rst) begin
        rst_req <= 1'b1;
        pcnt    <= PULSE_W'(RST_PULSE - 1);
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end else begin
        rst_req <= 1'b0;
      end
      if (fire_rst)     src_flag <= 1'b1;
      else if (src_clr) src_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por)          hi_len <= '0;
    else if (rst_req) hi_len <= hi_len + 1'b1;
    else              hi_len <= '0;
  end

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (por)
    rst_req |-> (hi_len < (PULSE_W+1)'(RST_PULSE)));
  p_src_with_pulse_r7: assert property (@(posedge clk) disable iff (por)
    $rose(src_flag) |-> $rose(rst_req));
  p_one_line_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nmi, irq}));
  p_nmi_needs_flag_r3: assert property (@(posedge clk) disable iff (rst)
    nmi |-> $past(exp_flag));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int CNT_W     = 32,
  parameter int RST_PULSE = 4
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o,
  output logic              nmi_o,
  output logic              irq_o
);
  logic             sys_rst;
  logic             en, load_wr, kick, exp_clr, src_clr;
  logic             exp_flag, src_flag, expire;
  wdog_act_e        act;
  logic [CNT_W-1:0] load_val, cnt;

  assign sys_rst = rst_i || por_i;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(sys_rst), .wr_en(bus_wr_i), .rd_en(bus_rd_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .cnt(cnt),
    .exp_flag(exp_flag), .src_flag(src_flag), .en(en), .act(act),
    .load_val(load_val), .load_wr(load_wr), .kick(kick),
    .exp_clr(exp_clr), .src_clr(src_clr), .rdata(bus_rdata_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(sys_rst), .en(en), .load_wr(load_wr),
    .load_data(bus_wdata_i[CNT_W-1:0]), .kick(kick), .load_val(load_val),
    .cnt(cnt), .expire(expire)
  );

  wdog_action #(.RST_PULSE(RST_PULSE)) u_action (
    .clk(clk), .rst(sys_rst), .por(por_i), .expire(expire), .act(act),
    .exp_clr(exp_clr), .src_clr(src_clr), .exp_flag(exp_flag),
    .src_flag(src_flag), .rst_req(rst_req_o), .nmi(nmi_o), .irq(irq_o)
  );
endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        por_i, rst_i, bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rst_req, nmi, irq;
  int          n_total = 0, n_pass = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(.RST_PULSE(PULSE)) u_wdog_top (
    .clk(clk), .por_i(por_i), .rst_i(rst_i), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .rst_req_o(rst_req), .nmi_o(nmi), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: got %0h expected %0h", req, act, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a[2:0];
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(0, d); check("R8 ctrl after reset", d, 0);
    rd(3, d); check("R8 count after reset", d, 0);
    check("R8 outputs after reset", {29'd0, rst_req, nmi, irq}, 0);
    wr(1, 32'h1234);
    rd(5, d); check("R9 unmapped read", d, 0);
    repeat (3) @(negedge clk);
    check("R9 rdata held without read", bus_rdata, 0);
  endtask

  task automatic t_countdown();
    logic [31:0] c1, c2;
    wr(1, 1000); wr(0, 32'h1);
    rd(3, c1);
    repeat (10) @(negedge clk);
    rd(3, c2);
    check("R1 decrement per cycle", c1 - c2, 11);
    wr(0, 0);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(1, 5); wr(0, 32'h5);
    repeat (5) @(negedge clk);
    check("R3 nmi not before latency", {31'd0, nmi}, 0);
    @(negedge clk);
    check("R3 nmi one cycle after expiry", {31'd0, nmi}, 1);
    check("R3 irq stays low with NMI", {31'd0, irq}, 0);
    rd(3, d); check("R2 count at zero", d, 0);
    repeat (3) @(negedge clk);
    rd(3, d); check("R2 count holds zero", d, 0);
    rd(0, d); check("R2 expired flag set", d, 32'h105);
    check("R3 nmi held until clear", {31'd0, nmi}, 1);
    wr(0, 32'h105);
    @(negedge clk);
    check("R3 nmi cleared by W1C", {31'd0, nmi}, 0);
    wr(0, 0);
  endtask

  task automatic t_irq();
    wr(1, 8); wr(0, 32'h7);
    repeat (8) @(negedge clk);
    check("R3 irq not early", {31'd0, irq}, 0);
    @(negedge clk);
    check("R3 irq raised", {30'd0, nmi, irq}, 1);
    wr(0, 32'h100);
    @(negedge clk);
    check("R3 irq cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    logic seen = 1'b0;
    wr(1, 20); wr(0, 32'h7);
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (irq) seen = 1'b1;
      end
      wr(2, 0);
    end
    check("R4 kicks prevent expiry", {31'd0, seen}, 0);
    rd(3, d); check("R4 count reloaded", {31'd0, (d > 15 && d <= 20)}, 1);
    repeat (25) @(negedge clk);
    check("R4 expiry once kicks stop", {31'd0, irq}, 1);
    wr(0, 32'h100);
  endtask

  task automatic t_freeze();
    logic [31:0] c1, c2, c3;
    wr(1, 50); wr(0, 32'h1);
    repeat (5) @(negedge clk);
    wr(0, 0);
    rd(3, c1);
    repeat (7) @(negedge clk);
    rd(3, c2);
    check("R5 count frozen while disabled", c2, c1);
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    rd(3, c3);
    check("R5 resumes without reload", {31'd0, (c3 < c2 && c3 + 10 > c2)}, 1);
    wr(0, 0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    wr(1, 3); wr(0, 32'h1);
    repeat (6) @(negedge clk);
    check("R10 no output on action none", {29'd0, rst_req, nmi, irq}, 0);
    rd(0, d); check("R10 flag set on action none", d, 32'h101);
    wr(0, 32'h100);
    rd(0, d); check("R10 flag cleared", d, 0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(1, 0); wr(0, 32'h5);
    repeat (10) @(negedge clk);
    check("R2 zero start never fires", {31'd0, nmi}, 0);
    rd(0, d); check("R2 zero start no flag", d, 32'h5);
    wr(0, 0);
  endtask

  task automatic t_reset_action();
    logic [31:0] d;
    int hi;
    wr(1, 4); wr(0, 32'h3);
    repeat (4) @(negedge clk);
    check("R6 reset request at expiry", {31'd0, rst_req}, 1);
    hi = 1;
    rst_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 1) rst_i = 1'b0;
      if (rst_req) hi++;
    end
    check("R6 pulse length", hi, PULSE);
    rd(0, d); check("R7 source flag survives rst", d, 32'h200);
    rd(3, d); check("R8 count cleared by rst", d, 0);
    check("R8 lines low after rst", {30'd0, nmi, irq}, 0);
    wr(0, 32'h200);
    rd(0, d); check("R7 source flag W1C", d, 0);
    wr(1, 2); wr(0, 32'h3);
    repeat (8) @(negedge clk);
    rd(0, d); check("R7 flag set again", d, 32'h303);
    por_i = 1'b1;
    repeat (2) @(negedge clk);
    por_i = 1'b0;
    rd(0, d); check("R7 por clears source flag", d, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    por_i = 1'b1; rst_i = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_countdown();
    t_nmi();
    t_irq();
    t_kick();
    t_freeze();
    t_none();
    t_zero();
    t_reset_action();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule